// File: doc/BRIEF.md
# Byte-Wide EEPROM Write Guard

This block sits between a host's asynchronous-style strobes (chip enable, output enable, write enable, all active low, sampled on the system clock) and the write port of a byte-wide nonvolatile array. It turns strobe activity into clean read and write events. It drops writes that the strobe levels forbid and writes whose enable pulse is too short. It also runs a command-sequence detector that can arm or disarm a protection flag. Once the flag is armed, only a write that directly follows the three-byte unlock sequence reaches the array.

Each accepted array write starts an internal write cycle of fixed length. During that cycle further writes are dropped, and bit 6 of the read data is replaced by a status bit that flips at the end of every read. A host can therefore poll for completion by reading twice and comparing. When the cycle finishes, reads return plain array data again. Command bytes are consumed by the detector and never reach the array.

Strobe decoder states: `B_IDLE`, `B_WLOW` (write enable held low, pulse width counted) and `B_READ` (chip enable and output enable both low). The transitions are: idle to `B_WLOW` on a low write enable; idle to `B_READ` on a read; `B_WLOW` to idle when write enable rises, which is the capture point; `B_READ` to idle when output enable or chip enable rises, which ends the read; `B_READ` to `B_WLOW` on a low write enable.

Sequence detector states: `SQ_IDLE`, `SQ_K1`, `SQ_K2` (first and second unlock bytes seen), `SQ_OPEN` (unlock complete, the next write passes) and `SQ_R3`, `SQ_R4`, `SQ_R5` (disarm bytes three to five seen). The transitions are: each matching byte advances one state. In `SQ_K2`, the third unlock byte goes to `SQ_OPEN` and arms the flag, while the third disarm byte goes to `SQ_R3`. `SQ_OPEN` returns to idle after passing one write. `SQ_R5` returns to idle and clears the flag on the sixth disarm byte. Any mismatching write returns to idle.

Write timer states: `T_READY` and `T_BUSY`. The timer goes from ready to busy on an accepted array write, and back to ready after the cycle count.

Top module: `eeprom_guard`

## Requirements
- R1: While a write cycle is busy, read data bit 6 takes a status value that inverts at the end of each read (output enable or chip enable rising after a read). Outside a busy cycle that status value holds and reads return the array byte unchanged.
- R2: A write is accepted only if, on the sample where write enable returns high, chip enable is low and output enable is high. A pulse with output enable low, or with chip enable high, changes nothing in the array.
- R3: After reset the protection flag is clear, and any non-command write goes to the array.
- R4: The unlock sequence (0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 by default, address/data) sets the protection flag. The flag stays set across later writes until the disarm sequence completes.
- R5: The bytes of the unlock sequence are never written into the array.
- R6: With the flag set, a write passes to the array only if it directly follows a complete unlock sequence. Any other write is dropped.
- R7: A write enable low time of fewer than MIN_WE samples starts no write. Exactly MIN_WE samples is enough.
- R8: A write that does not match the expected next command byte returns the detector to idle, so a later partial sequence cannot complete an unlock.
- R9: An accepted array write produces a one-cycle array write pulse and a busy period of WR_CYC cycles. Writes arriving during that period are dropped.
- R10: The six-byte disarm sequence (the first two unlock bytes, then 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20) clears the flag and writes none of its bytes.
- R11: Address and data are taken from the bus on the sample where write enable rises. Values present earlier in the pulse are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| wdata | input | DW | Host write data |
| rd_data | output | DW | Host read data (array byte, with bit 6 as status while busy) |
| mem_rdata | input | DW | Byte read from the array at `addr` |
| mem_we | output | 1 | Array write pulse, one cycle |
| mem_waddr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |

## Verification
The capture decision falls on the first clock edge that sees write enable high. The array write pulse follows one edge later, and the bench's array model stores the byte on the edge after that. For this reason every read-back in the bench starts at least one falling edge after the write task has released chip enable. The status bit inverts on the edge after a read ends, so each read is sampled on the falling edge before output enable is released. A comparison of two consecutive busy reads therefore sees exactly one inversion. Before each check that expects plain array data, the bench waits WR_CYC plus four cycles, so the busy period has ended by then.

// File: rtl/eeprom_guard_pkg.sv
package eeprom_guard_pkg;

    typedef enum logic [1:0] {
        B_IDLE,
        B_WLOW,
        B_READ
    } bus_st_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_OPEN,
        SQ_R3,
        SQ_R4,
        SQ_R5
    } seq_st_t;

    typedef enum logic {
        T_READY,
        T_BUSY
    } tmr_st_t;

    localparam int TOG_BIT = 6;

endpackage

// File: rtl/eeprom_guard_strobe.sv
module eeprom_guard_strobe
    import eeprom_guard_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int MIN_WE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_evt,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_done
);

    localparam int CW = $clog2(MIN_WE + 1);

    bus_st_t         st, st_nx;
    logic [CW-1:0]   lo_cnt, lo_cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= B_IDLE;
            lo_cnt <= '0;
        end else begin
            st     <= st_nx;
            lo_cnt <= lo_cnt_nx;
        end
    end

    // transitions and outputs
    always_comb begin
        st_nx     = st;
        lo_cnt_nx = lo_cnt;
        wr_evt    = 1'b0;
        rd_done   = 1'b0;
        unique case (st)
            B_IDLE: begin
                if (!we_n) begin
                    st_nx     = B_WLOW;
                    lo_cnt_nx = CW'(1);
                end else if (!ce_n && !oe_n) begin
                    st_nx = B_READ;
                end
            end
            B_WLOW: begin
                if (we_n) begin
                    st_nx     = B_IDLE;
                    lo_cnt_nx = '0;
                    wr_evt    = (lo_cnt >= CW'(MIN_WE)) && !ce_n && oe_n;
                end else if (lo_cnt < CW'(MIN_WE)) begin
                    lo_cnt_nx = lo_cnt + CW'(1);
                end
            end
            B_READ: begin
                if (!we_n) begin
                    st_nx     = B_WLOW;
                    lo_cnt_nx = CW'(1);
                end else if (oe_n || ce_n) begin
                    st_nx   = B_IDLE;
                    rd_done = 1'b1;
                end
            end
            default: st_nx = B_IDLE;
        endcase
    end

    // bus values are taken on the rising-WE sample itself
    assign wr_addr = addr;
    assign wr_data = wdata;

endmodule

// File: rtl/eeprom_guard_seq.sv
module eeprom_guard_seq
    import eeprom_guard_pkg::*;
#(
    parameter int            AW   = 16,
    parameter int            DW   = 8,
    parameter logic [AW-1:0] A_K1 = 16'h5555,
    parameter logic [DW-1:0] D_K1 = 8'hAA,
    parameter logic [AW-1:0] A_K2 = 16'h2AAA,
    parameter logic [DW-1:0] D_K2 = 8'h55,
    parameter logic [AW-1:0] A_K3 = 16'h5555,
    parameter logic [DW-1:0] D_K3 = 8'hA0,
    parameter logic [AW-1:0] A_R3 = 16'h5555,
    parameter logic [DW-1:0] D_R3 = 8'h80,
    parameter logic [AW-1:0] A_R4 = 16'h5555,
    parameter logic [DW-1:0] D_R4 = 8'hAA,
    parameter logic [AW-1:0] A_R5 = 16'h2AAA,
    parameter logic [DW-1:0] D_R5 = 8'h55,
    parameter logic [AW-1:0] A_R6 = 16'h5555,
    parameter logic [DW-1:0] D_R6 = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_evt,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    output logic          arr_req,
    output logic          armed,
    output seq_st_t       state
);

    seq_st_t st_nx;
    logic    armed_nx;
    logic    evt;
    logic    hit_k1, hit_k2, hit_k3, hit_r3, hit_r4, hit_r5, hit_r6;

    assign evt    = wr_evt && !busy;
    assign hit_k1 = (wr_addr == A_K1) && (wr_data == D_K1);
    assign hit_k2 = (wr_addr == A_K2) && (wr_data == D_K2);
    assign hit_k3 = (wr_addr == A_K3) && (wr_data == D_K3);
    assign hit_r3 = (wr_addr == A_R3) && (wr_data == D_R3);
    assign hit_r4 = (wr_addr == A_R4) && (wr_data == D_R4);
    assign hit_r5 = (wr_addr == A_R5) && (wr_data == D_R5);
    assign hit_r6 = (wr_addr == A_R6) && (wr_data == D_R6);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            armed <= 1'b0;
        end else begin
            state <= st_nx;
            armed <= armed_nx;
        end
    end

    // transitions and outputs
    always_comb begin
        st_nx    = state;
        armed_nx = armed;
        arr_req  = 1'b0;
        if (evt) begin
            unique case (state)
                SQ_IDLE: begin
                    if (hit_k1) st_nx = SQ_K1;
                    else        arr_req = !armed;
                end
                SQ_K1: begin
                    if (hit_k2) begin
                        st_nx = SQ_K2;
                    end else begin
                        st_nx   = SQ_IDLE;
                        arr_req = !armed;
                    end
                end
                SQ_K2: begin
                    if (hit_k3) begin
                        st_nx    = SQ_OPEN;
                        armed_nx = 1'b1;
                    end else if (hit_r3) begin
                        st_nx = SQ_R3;
                    end else begin
                        st_nx   = SQ_IDLE;
                        arr_req = !armed;
                    end
                end
                SQ_OPEN: begin
                    st_nx   = SQ_IDLE;
                    arr_req = 1'b1;
                end
                SQ_R3: begin
                    if (hit_r4) begin
                        st_nx = SQ_R4;
                    end else begin
                        st_nx   = SQ_IDLE;
                        arr_req = !armed;
                    end
                end
                SQ_R4: begin
                    if (hit_r5) begin
                        st_nx = SQ_R5;
                    end else begin
                        st_nx   = SQ_IDLE;
                        arr_req = !armed;
                    end
                end
                SQ_R5: begin
                    st_nx = SQ_IDLE;
                    if (hit_r6) armed_nx = 1'b0;
                    else        arr_req  = !armed;
                end
                default: st_nx = SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_guard_timer.sv
module eeprom_guard_timer
    import eeprom_guard_pkg::*;
#(
    parameter int WR_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_done,
    output logic busy,
    output logic tog
);

    localparam int CW = $clog2(WR_CYC + 1);

    tmr_st_t       st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          tog_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= T_READY;
            cnt <= '0;
            tog <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            tog <= tog_nx;
        end
    end

    // transitions and outputs
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        tog_nx = tog;
        unique case (st)
            T_READY: begin
                if (start) begin
                    st_nx  = T_BUSY;
                    cnt_nx = CW'(WR_CYC - 1);
                end
            end
            T_BUSY: begin
                if (rd_done) tog_nx = !tog;
                if (cnt == '0) st_nx = T_READY;
                else           cnt_nx = cnt - CW'(1);
            end
            default: st_nx = T_READY;
        endcase
    end

    assign busy = (st == T_BUSY);

endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
    import eeprom_guard_pkg::*;
#(
    parameter int            AW     = 16,
    parameter int            DW     = 8,
    parameter int            MIN_WE = 3,
    parameter int            WR_CYC = 40,
    parameter logic [AW-1:0] A_K1   = 16'h5555,
    parameter logic [DW-1:0] D_K1   = 8'hAA,
    parameter logic [AW-1:0] A_K2   = 16'h2AAA,
    parameter logic [DW-1:0] D_K2   = 8'h55,
    parameter logic [AW-1:0] A_K3   = 16'h5555,
    parameter logic [DW-1:0] D_K3   = 8'hA0,
    parameter logic [AW-1:0] A_R3   = 16'h5555,
    parameter logic [DW-1:0] D_R3   = 8'h80,
    parameter logic [AW-1:0] A_R4   = 16'h5555,
    parameter logic [DW-1:0] D_R4   = 8'hAA,
    parameter logic [AW-1:0] A_R5   = 16'h2AAA,
    parameter logic [DW-1:0] D_R5   = 8'h55,
    parameter logic [AW-1:0] A_R6   = 16'h5555,
    parameter logic [DW-1:0] D_R6   = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);

    logic          wr_evt, rd_done, arr_req, busy, tog, armed;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    seq_st_t       seq_state;

    eeprom_guard_strobe #(.AW(AW), .DW(DW), .MIN_WE(MIN_WE)) strobe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_evt  (wr_evt),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_done (rd_done)
    );

    eeprom_guard_seq #(
        .AW(AW), .DW(DW),
        .A_K1(A_K1), .D_K1(D_K1), .A_K2(A_K2), .D_K2(D_K2),
        .A_K3(A_K3), .D_K3(D_K3), .A_R3(A_R3), .D_R3(D_R3),
        .A_R4(A_R4), .D_R4(D_R4), .A_R5(A_R5), .D_R5(D_R5),
        .A_R6(A_R6), .D_R6(D_R6)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_evt  (wr_evt),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .arr_req (arr_req),
        .armed   (armed),
        .state   (seq_state)
    );

    eeprom_guard_timer #(.WR_CYC(WR_CYC)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (arr_req),
        .rd_done (rd_done),
        .busy    (busy),
        .tog     (tog)
    );

    // array write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= arr_req;
            if (arr_req) begin
                mem_waddr <= wr_addr;
                mem_wdata <= wr_data;
            end
        end
    end

    // read path: status bit substituted while busy
    always_comb begin
        rd_data = mem_rdata;
        if (busy) rd_data[TOG_BIT] = tog;
    end

endmodule

// File: rtl/eeprom_guard_chk.sv
module eeprom_guard_chk
    import eeprom_guard_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    ce_n,
    input logic    oe_n,
    input logic    we_n,
    input logic    mem_we,
    input logic    busy,
    input logic    tog,
    input logic    armed,
    input seq_st_t seq_state
);

    p_tog_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tog));

    p_write_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(!ce_n && oe_n && we_n));

    p_arm_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(seq_state) == SQ_K2);

    p_bare_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(armed)) |-> $past(seq_state) == SQ_OPEN);

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

endmodule

bind eeprom_guard eeprom_guard_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .mem_we    (mem_we),
    .busy      (busy),
    .tog       (tog),
    .armed     (armed),
    .seq_state (seq_state)
);

// File: tb/eeprom_guard_tb_top.sv
module eeprom_guard_tb_top;

    localparam int AW     = 16;
    localparam int DW     = 8;
    localparam int MIN_WE = 3;
    localparam int WR_CYC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data, mem_rdata, mem_wdata;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] bmem [256];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = !clk;

    eeprom_guard #(.AW(AW), .DW(DW), .MIN_WE(MIN_WE), .WR_CYC(WR_CYC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .wdata     (wdata),
        .rd_data   (rd_data),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    // array model, indexed by the low address byte
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'h00;
        end else if (mem_we) begin
            bmem[mem_waddr[7:0]] <= mem_wdata;
        end
    end
    assign mem_rdata = bmem[addr[7:0]];

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write_sw(input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                                input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                                input int n, input logic ce_v, input logic oe_v);
        @(negedge clk);
        ce_n = ce_v; oe_n = oe_v; addr = a0; wdata = d0; we_n = 1'b0;
        repeat (n - 1) @(negedge clk);
        addr = a1; wdata = d1;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; addr = '0;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_write_sw(a, d, a, d, MIN_WE, 1'b0, 1'b1);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        v = rd_data;
        oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic settle();
        repeat (WR_CYC + 4) @(negedge clk);
    endtask

    task automatic send_unlock();
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h5555, 8'hA0);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check("R3 reset mem_we", {7'd0, mem_we}, 8'h00);
        bus_read(16'h0010, v);
        check("R3 reset read", v, 8'h00);
    endtask

    task automatic t_plain_and_capture();
        logic [DW-1:0] v;
        bus_write_sw(16'h0011, 8'h00, 16'h0010, 8'h5A, MIN_WE, 1'b0, 1'b1);
        settle();
        bus_read(16'h0010, v);
        check("R3 R11 late value written", v, 8'h5A);
        bus_read(16'h0011, v);
        check("R11 early address unused", v, 8'h00);
    endtask

    task automatic t_toggle();
        logic [DW-1:0] v1, v2;
        bus_write(16'h0020, 8'h0F);
        bus_read(16'h0020, v1);
        bus_read(16'h0020, v2);
        check("R1 bit6 inverts while busy", {7'd0, v1[6] ^ v2[6]}, 8'h01);
        settle();
        bus_read(16'h0020, v1);
        bus_read(16'h0020, v2);
        check("R1 first read after cycle", v1, 8'h0F);
        check("R1 second read after cycle", v2, 8'h0F);
    endtask

    task automatic t_busy_drop();
        logic [DW-1:0] v;
        bus_write(16'h0030, 8'h11);
        bus_write(16'h0031, 8'h22);
        settle();
        bus_read(16'h0031, v);
        check("R9 write during busy dropped", v, 8'h00);
        bus_read(16'h0030, v);
        check("R9 first write kept", v, 8'h11);
    endtask

    task automatic t_short_pulse();
        logic [DW-1:0] v;
        bus_write_sw(16'h0040, 8'h33, 16'h0040, 8'h33, MIN_WE - 1, 1'b0, 1'b1);
        settle();
        bus_read(16'h0040, v);
        check("R7 short pulse ignored", v, 8'h00);
        bus_write_sw(16'h0040, 8'h33, 16'h0040, 8'h33, MIN_WE, 1'b0, 1'b1);
        settle();
        bus_read(16'h0040, v);
        check("R7 minimum pulse accepted", v, 8'h33);
    endtask

    task automatic t_inhibit();
        logic [DW-1:0] v;
        bus_write_sw(16'h0050, 8'h66, 16'h0050, 8'h66, MIN_WE, 1'b0, 1'b0);
        settle();
        bus_read(16'h0050, v);
        check("R2 OE low blocks", v, 8'h00);
        bus_write_sw(16'h0051, 8'h66, 16'h0051, 8'h66, MIN_WE, 1'b1, 1'b1);
        settle();
        bus_read(16'h0051, v);
        check("R2 CE high blocks", v, 8'h00);
    endtask

    task automatic t_enable();
        logic [DW-1:0] v;
        send_unlock();
        bus_write(16'h0060, 8'h77);
        settle();
        bus_read(16'h5555, v);
        check("R5 unlock byte at 5555 not stored", v, 8'h00);
        bus_read(16'h2AAA, v);
        check("R5 unlock byte at 2AAA not stored", v, 8'h00);
        bus_read(16'h0060, v);
        check("R6 write after unlock stored", v, 8'h77);
        bus_write(16'h0061, 8'h12);
        settle();
        bus_read(16'h0061, v);
        check("R6 bare write dropped", v, 8'h00);
        bus_write(16'h0062, 8'h34);
        settle();
        bus_read(16'h0062, v);
        check("R4 protection persists", v, 8'h00);
    endtask

    task automatic t_broken();
        logic [DW-1:0] v;
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h56);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h5555, 8'hA0);
        bus_write(16'h0070, 8'h99);
        settle();
        bus_read(16'h0070, v);
        check("R8 broken sequence gives no unlock", v, 8'h00);
        bus_read(16'h2AAA, v);
        check("R8 mismatch byte dropped while armed", v, 8'h00);
    endtask

    task automatic t_disarm();
        logic [DW-1:0] v;
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h5555, 8'h80);
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h5555, 8'h20);
        settle();
        bus_read(16'h5555, v);
        check("R10 disarm bytes not stored", v, 8'h00);
        bus_write(16'h0080, 8'h44);
        settle();
        bus_read(16'h0080, v);
        check("R10 bare write after disarm stored", v, 8'h44);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_and_capture();
        t_toggle();
        t_busy_drop();
        t_short_pulse();
        t_inhibit();
        t_enable();
        t_broken();
        t_disarm();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule